// File: doc/BRIEF.md
# Fault Supervisor with Per-Source Error Routing

This block gathers three error indications from a fault-tolerant processor system: the integer unit entering error mode, a mismatch reported by the integer-unit comparison logic, and a hardware fault inside the memory controller. Each one arrives as a single-cycle strobe. The block records it in a status register. A control register then decides what happens for that source: a level-1 interrupt request, a system halt, or a system reset.

Software reaches the control and status words through a small word-addressed register port. Writing the control word with its injection bit set creates a memory-controller fault, so the handling path can be tested from software. A halt is a level that follows a sticky status flag. A reset is a one-cycle pulse, and it also replaces the whole status word with a single marker value.

Top module: `fsup_top`

## Requirements
- R1: After the synchronous reset `rst`, the control word reads 0x01350014, the status word reads 0, and `sys_rst_pulse`, `sys_halt` and `irq_l1` are all low.
- R2: Each error strobe sets its own status bit: the error-mode strobe sets bit 0, the comparison strobe sets bit 2, and the memory-controller strobe sets bit 5. The bit is set on the clock edge that samples the strobe. Earlier status bits are kept.
- R3: A source is routed to interrupt when its routing bit in the control word is 1: bit 5 for error mode, bit 9 for comparison, bit 13 for memory controller. For such a source, `irq_l1` is high for exactly the one cycle after the edge that samples the strobe, and there is no halt or reset.
- R4: A source whose routing bit is 0 and whose reset-select bit is 0 causes a halt. The reset-select bits are bit 6, bit 10 and bit 14, in the same source order as R3. A halt sets status bit 13 and keeps all other status bits. `sys_halt` always equals status bit 13, so it stays high until status is rewritten or an error reset occurs.
- R5: A source whose routing bit is 0 and whose reset-select bit is 1 causes a reset. `sys_rst_pulse` is high for exactly one cycle after the sampling edge, and the status word becomes exactly 0x8000.
- R6: When several sources are handled on the same edge, reset beats halt and halt beats interrupt. Every source that fired still records its status bit, except when the outcome is a reset.
- R7: A control-word write with bit 15 set acts as a memory-controller strobe on that same edge. It is routed by the newly written control value. Bit 15 is never stored and always reads 0.
- R8: Word address 0 is the control word and address 1 is the status word, zero-extended to 32 bits. A status write keeps only bits 0, 2, 5, 13 and 15. Other addresses read 0, and writes to them change nothing.
- R9: If a status write and an error strobe fall on the same edge, the error handling is applied on top of the written value.
- R10: An error-triggered reset leaves the control word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| errmode_stb | input | 1 | Integer unit entered error mode (one-cycle strobe) |
| compare_stb | input | 1 | Integer-unit comparison mismatch (one-cycle strobe) |
| memctl_stb | input | 1 | Memory-controller hardware fault (one-cycle strobe) |
| bus_wr | input | 1 | Register write enable |
| bus_addr | input | ADDR_W | Word address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| sys_rst_pulse | output | 1 | One-cycle system reset request |
| sys_halt | output | 1 | System halt level (mirrors status bit 13) |
| irq_l1 | output | 1 | One-cycle level-1 interrupt request |

## Verification
Every decision is registered on the edge that samples the strobe, so a wrong routing or priority choice shows at `irq_l1`, `sys_halt` or `sys_rst_pulse` in the very next cycle. A corrupt status word is visible in two places at once. It shows at once at `sys_halt` when bit 13 is wrong, and on the next read of address 1 for any other bit. A lost or extra pulse is caught by checking the cycle after each event as well as the event cycle. An injection that used the old control value instead of the new one produces the wrong kind of action and is therefore seen at the outputs.

// File: rtl/fsup_pkg.sv
package fsup_pkg;

    localparam int NSRC   = 3;
    localparam int DATA_W = 32;
    localparam int STAT_W = 16;

    localparam logic [DATA_W-1:0] CTRL_RST_VAL = 32'h0135_0014;
    localparam logic [STAT_W-1:0] STAT_RST_MARK = 16'h8000;
    localparam logic [STAT_W-1:0] STAT_WR_MASK  = 16'hA025;
    localparam int HALT_POS = 13;
    localparam int INJ_POS  = 15;

    // ordered so that a larger code wins arbitration
    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_IRQ  = 2'd1,
        ACT_HALT = 2'd2,
        ACT_RST  = 2'd3
    } act_e;

    typedef struct packed {
        logic hit;
        act_e act;
    } src_dec_t;

    // status flag position per source (0: error mode, 1: compare, 2: memctl)
    function automatic int stat_pos(input int s);
        case (s)
            0:       return 0;
            1:       return 2;
            default: return 5;
        endcase
    endfunction

    function automatic int route_pos(input int s);
        return 5 + 4 * s;
    endfunction

    function automatic int rsel_pos(input int s);
        return 6 + 4 * s;
    endfunction

endpackage

// File: rtl/fsup_route.sv
module fsup_route
    import fsup_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic              stb,
    input  logic [DATA_W-1:0] ctrl,
    output src_dec_t          dec
);

    localparam int RP = route_pos(IDX);
    localparam int RS = rsel_pos(IDX);

    always_comb begin
        dec.hit = stb;
        if (!stb)
            dec.act = ACT_NONE;
        else if (ctrl[RP])
            dec.act = ACT_IRQ;
        else if (ctrl[RS])
            dec.act = ACT_RST;
        else
            dec.act = ACT_HALT;
    end

endmodule

// File: rtl/fsup_arb.sv
module fsup_arb
    import fsup_pkg::*;
(
    input  src_dec_t [NSRC-1:0] dec,
    output act_e                act,
    output logic [STAT_W-1:0]   hit_bits
);

    always_comb begin
        act      = ACT_NONE;
        hit_bits = '0;
        for (int s = 0; s < NSRC; s++) begin
            if (dec[s].hit)
                hit_bits[stat_pos(s)] = 1'b1;
            if (dec[s].act > act)
                act = dec[s].act;
        end
    end

endmodule

// File: rtl/fsup_regs.sv
module fsup_regs
    import fsup_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  act_e              act,
    input  logic [STAT_W-1:0] hit_bits,
    output logic [DATA_W-1:0] ctrl_eff,
    output logic              inject,
    output logic              wr_ctrl,
    output logic              wr_stat,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [STAT_W-1:0] stat_q,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              sys_rst_pulse,
    output logic              sys_halt,
    output logic              irq_l1
);

    localparam logic [ADDR_W-1:0] A_CTRL = '0;
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(1);
    localparam logic [DATA_W-1:0] INJ_BIT = DATA_W'(1) << INJ_POS;
    localparam logic [STAT_W-1:0] HALT_BIT = STAT_W'(1) << HALT_POS;

    logic [DATA_W-1:0] ctrl_d;
    logic [STAT_W-1:0] stat_base, stat_d;
    logic              rstp_q, irq_q;

    assign wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
    assign wr_stat  = bus_wr && (bus_addr == A_STAT);
    assign ctrl_eff = wr_ctrl ? bus_wdata : ctrl_q;
    assign inject   = wr_ctrl && bus_wdata[INJ_POS];
    assign ctrl_d   = wr_ctrl ? (bus_wdata & ~INJ_BIT) : ctrl_q;

    always_comb begin
        stat_base = wr_stat ? (bus_wdata[STAT_W-1:0] & STAT_WR_MASK) : stat_q;
        case (act)
            ACT_RST:  stat_d = STAT_RST_MARK;
            ACT_HALT: stat_d = stat_base | hit_bits | HALT_BIT;
            default:  stat_d = stat_base | hit_bits;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RST_VAL;
            stat_q <= '0;
            rstp_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            ctrl_q <= ctrl_d;
            stat_q <= stat_d;
            rstp_q <= (act == ACT_RST);
            irq_q  <= (act == ACT_IRQ);
        end
    end

    always_comb begin
        case (bus_addr)
            A_CTRL:  bus_rdata = ctrl_q;
            A_STAT:  bus_rdata = {{(DATA_W-STAT_W){1'b0}}, stat_q};
            default: bus_rdata = '0;
        endcase
    end

    assign sys_rst_pulse = rstp_q;
    assign irq_l1        = irq_q;
    assign sys_halt      = stat_q[HALT_POS];

endmodule

// File: rtl/fsup_top.sv
module fsup_top
    import fsup_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              errmode_stb,
    input  logic              compare_stb,
    input  logic              memctl_stb,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              sys_rst_pulse,
    output logic              sys_halt,
    output logic              irq_l1
);

    logic [DATA_W-1:0]   ctrl_eff;
    logic [DATA_W-1:0]   ctrl_q;
    logic [STAT_W-1:0]   stat_q;
    logic [STAT_W-1:0]   hit_bits;
    logic                inject;
    logic                wr_ctrl;
    logic                wr_stat;
    logic [NSRC-1:0]     src_stb;
    src_dec_t [NSRC-1:0] dec;
    act_e                act;

    assign src_stb = {memctl_stb | inject, compare_stb, errmode_stb};

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        fsup_route #(.IDX(g)) u_route (
            .stb  (src_stb[g]),
            .ctrl (ctrl_eff),
            .dec  (dec[g])
        );
    end

    fsup_arb u_arb (
        .dec      (dec),
        .act      (act),
        .hit_bits (hit_bits)
    );

    fsup_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk           (clk),
        .rst           (rst),
        .bus_wr        (bus_wr),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .act           (act),
        .hit_bits      (hit_bits),
        .ctrl_eff      (ctrl_eff),
        .inject        (inject),
        .wr_ctrl       (wr_ctrl),
        .wr_stat       (wr_stat),
        .ctrl_q        (ctrl_q),
        .stat_q        (stat_q),
        .bus_rdata     (bus_rdata),
        .sys_rst_pulse (sys_rst_pulse),
        .sys_halt      (sys_halt),
        .irq_l1        (irq_l1)
    );

endmodule

// File: rtl/fsup_chk.sv
module fsup_chk (
    input logic        clk,
    input logic        rst,
    input logic        errmode_stb,
    input logic        compare_stb,
    input logic        memctl_stb,
    input logic        wr_ctrl,
    input logic        wr_stat,
    input logic [31:0] bus_wdata,
    input logic [31:0] ctrl_q,
    input logic [15:0] stat_q,
    input logic        sys_rst_pulse,
    input logic        sys_halt,
    input logic        irq_l1
);

    // R5
    rst_mark_chk: assert property (@(posedge clk) disable iff (rst)
        sys_rst_pulse |-> stat_q == 16'h8000);

    // R4
    halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sys_halt && !wr_stat) |=> (sys_halt || sys_rst_pulse));

    // R6
    act_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sys_rst_pulse, irq_l1}));

    // R3
    irq_route_chk: assert property (@(posedge clk) disable iff (rst)
        (errmode_stb && !compare_stb && !memctl_stb && !wr_ctrl && ctrl_q[5])
        |=> irq_l1);

    // R7
    inject_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && bus_wdata[15]) |=> (!ctrl_q[15] && (stat_q[5] || stat_q == 16'h8000)));

endmodule

bind fsup_top fsup_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .errmode_stb   (errmode_stb),
    .compare_stb   (compare_stb),
    .memctl_stb    (memctl_stb),
    .wr_ctrl       (wr_ctrl),
    .wr_stat       (wr_stat),
    .bus_wdata     (bus_wdata),
    .ctrl_q        (ctrl_q),
    .stat_q        (stat_q),
    .sys_rst_pulse (sys_rst_pulse),
    .sys_halt      (sys_halt),
    .irq_l1        (irq_l1)
);

// File: tb/fsup_top_test.sv
module fsup_top_test;

    localparam int ADDR_W = 2;
    localparam logic [31:0] CDEF = 32'h0135_0014;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              errmode_stb = 1'b0;
    logic              compare_stb = 1'b0;
    logic              memctl_stb = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              sys_rst_pulse, sys_halt, irq_l1;

    int nvec = 0;
    int nbad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    fsup_top #(.ADDR_W(ADDR_W)) uut (
        .clk           (clk),
        .rst           (rst),
        .errmode_stb   (errmode_stb),
        .compare_stb   (compare_stb),
        .memctl_stb    (memctl_stb),
        .bus_wr        (bus_wr),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .sys_rst_pulse (sys_rst_pulse),
        .sys_halt      (sys_halt),
        .irq_l1        (irq_l1)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        nvec++;
        if (got !== exp) begin
            nbad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // outputs {rst_pulse, halt, irq}
    task automatic chk_out(input string req, input logic [2:0] exp);
        chk(req, {29'd0, sys_rst_pulse, sys_halt, irq_l1}, {29'd0, exp});
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic chk_reg(input string req, input logic [ADDR_W-1:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(req, d, exp);
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // strobes: bit0 error mode, bit1 compare, bit2 memctl
    task automatic fire(input logic [2:0] s);
        @(negedge clk);
        errmode_stb = s[0]; compare_stb = s[1]; memctl_stb = s[2];
        @(negedge clk);
        errmode_stb = 1'b0; compare_stb = 1'b0; memctl_stb = 1'b0;
    endtask

    task automatic t_reset;
        chk_out("R1 outputs", 3'b000);
        chk_reg("R1 control", 0, CDEF);
        chk_reg("R1 status", 1, 32'h0);
    endtask

    task automatic t_irq;
        wr(0, CDEF | 32'h2220);
        fire(3'b001);
        chk_out("R3 irq error mode", 3'b001);
        chk_reg("R2 bit0", 1, 32'h0001);
        @(negedge clk);
        chk_out("R3 irq one cycle", 3'b000);
        fire(3'b010);
        chk_out("R3 irq compare", 3'b001);
        chk_reg("R2 bit2", 1, 32'h0005);
        fire(3'b100);
        chk_out("R3 irq memctl", 3'b001);
        chk_reg("R2 bit5", 1, 32'h0025);
        wr(1, 32'h0);
    endtask

    task automatic t_halt;
        wr(0, CDEF);
        wr(1, 32'h0001);
        fire(3'b010);
        chk_out("R4 halt raised", 3'b010);
        chk_reg("R4 status keeps flags", 1, 32'h2005);
        repeat (3) @(negedge clk);
        chk_out("R4 halt sticky", 3'b010);
        wr(1, 32'h0);
        chk_out("R4 halt released by status write", 3'b000);
    endtask

    task automatic t_rst;
        wr(0, CDEF | 32'h0040);
        wr(1, 32'h2025);
        chk_out("R8 status write sets halt", 3'b010);
        fire(3'b001);
        chk_out("R5 reset pulse", 3'b100);
        chk_reg("R5 status mark", 1, 32'h8000);
        @(negedge clk);
        chk_out("R5 pulse one cycle", 3'b000);
        chk_reg("R10 control kept", 0, CDEF | 32'h0040);
    endtask

    task automatic t_prio;
        wr(0, CDEF | 32'h4020);
        wr(1, 32'h0);
        fire(3'b011);
        chk_out("R6 halt over irq", 3'b010);
        chk_reg("R6 halt status", 1, 32'h2005);
        wr(1, 32'h0);
        fire(3'b111);
        chk_out("R6 reset over all", 3'b100);
        chk_reg("R6 reset status", 1, 32'h8000);
        fire(3'b001);
        chk_out("R6 irq alone", 3'b001);
        chk_reg("R2 after mark", 1, 32'h8001);
    endtask

    task automatic t_inject;
        wr(1, 32'h0);
        wr(0, CDEF | 32'hA000);
        chk_out("R7 inject irq via new control", 3'b001);
        chk_reg("R7 inject status", 1, 32'h0020);
        chk_reg("R7 bit15 not stored", 0, CDEF | 32'h2000);
        wr(0, CDEF | 32'hC000);
        chk_out("R7 inject reset", 3'b100);
        chk_reg("R7 inject reset status", 1, 32'h8000);
    endtask

    task automatic t_bus;
        wr(0, CDEF);
        wr(2, 32'hFFFF_FFFF);
        chk_reg("R8 unmapped reads 0", 2, 32'h0);
        chk_reg("R8 unmapped write ignored ctrl", 0, CDEF);
        chk_reg("R8 unmapped write ignored stat", 1, 32'h8000);
        wr(1, 32'hFFFF_FFFF);
        chk_reg("R8 status mask", 1, 32'h0000A025);
        // R9: status write and error strobe on one edge
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 1; bus_wdata = 32'h0004; errmode_stb = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; errmode_stb = 1'b0;
        chk_out("R9 halt on written value", 3'b010);
        chk_reg("R9 merged status", 1, 32'h2005);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_irq();
        t_halt();
        t_rst();
        t_prio();
        t_inject();
        t_bus();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nvec++;
            nbad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

endmodule